// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A synthesizable model of a pipelined synchronous static RAM with words of four 9-bit byte lanes (36 bits at the default sizes). The address, the three chip selects, the write controls and the write data are sampled on the rising clock edge. Read data leaves an output register one edge after the address is taken. A separate drive-enable output takes the place of a three-state bus.

Two address strobes can start an access. The processor-side strobe has a write latency of two edges: its own edge only captures the address, and the write happens on the edge after it. The controller-side strobe writes on its own edge. A 2-bit burst counter steps through a block of four words, in linear or interleaved order. The output drive follows a double-cycle deselect pipeline, waits one cycle when the device is reselected, and is forced off whenever a write is about to commit.

Top module: `burst_ssram`

## Requirements
- R1: A strobe edge with all three selects active (`sel_main_n`=0, `sel_hi`=1, `sel_lo_n`=0) and no lane write requested starts a read. The word at the captured address sits on `dout` after the next rising edge, and `dout_en` is high while `out_en_n` is low.
- R2: While `sel_main_n` is high, a low `cpu_strobe_n` is ignored. No access starts, and an access that is already running goes on unchanged.
- R3: Reads started on back-to-back strobe edges return their words on back-to-back cycles, in the same order.
- R4: On a processor-strobe edge the write controls have no effect. The write happens on the following edge and uses the controls and data sampled on that edge.
- R5: A controller strobe, accepted while the processor strobe is not, with all selects active and a lane write requested, writes `din` to `addr` on that same edge.
- R6: A lane i (bits 9i+8 down to 9i) is written when `all_wr_n` is low, whatever the other write inputs are. It is also written when `lane_wr_en_n` and `lane_sel_n[i]` are both low. Lanes that are not written keep their contents.
- R7: After an edge that selects the device while it was deselected, `dout_en` stays low for one cycle.
- R8: A strobe edge with any select inactive deselects the device. `dout_en` still presents the previous read for one more cycle, and it is low after the edge that follows.
- R9: `dout_en` is low in every cycle in which a write will commit on the coming edge. No read data is driven until two edges after a write.
- R10: `out_en_n` high forces `dout_en` low in the same cycle, without waiting for a clock edge.
- R11: On an edge with no strobe, while an access is active, `advance_n` low steps the 2-bit counter. With `seq_linear`=1 the low two address bits are base plus count modulo 4. With `seq_linear`=0 they are base XOR count. A read edge outputs the address as it was before the step. A write edge writes the address after the step.
- R12: While `rst_n` is low on a rising edge, the output register is cleared, the device is deselected and `dout_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, qualified by `sel_main_n` |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| sel_main_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| addr | input | AW (6) | Word address |
| advance_n | input | 1 | Burst counter step, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Enable for per-lane writes, active low |
| lane_sel_n | input | LANES (4) | Per-lane write selects, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Output enable, active low, combinational |
| din | input | DW (36) | Write data |
| dout | output | DW (36) | Output register contents |
| dout_en | output | 1 | Drive enable for `dout` |

## Verification
On every cycle the assertions check the parts of the output-enable logic that depend on a single cycle or a single edge. `dout_en` is low whenever a write is pending or `out_en_n` is high, it stays low after reselection and after an idle or deselected cycle, a processor-strobe edge never writes, the global write sets every lane enable, and a processor strobe without the primary select never activates the device. Data integrity needs the bench's scenarios, which compare every driven word against a shadow memory. These cover lane merging, the two write latencies, the strobe-cycle data being ignored, both burst orders with wraparound, pipelined back-to-back reads and the extra driven cycle after a deselect.

// File: rtl/ssram_pkg.sv
// Package ssram_pkg
// Shared types and the burst-order function for the pipelined SRAM model.
// Assumes a burst block of 2**BURST_W words aligned on the low address bits.
package ssram_pkg;

    localparam int BURST_W = 2;

    // Per-edge sequencing decisions from the access controller.
    typedef struct packed {
        logic load;   // strobe accepted: capture a new base address
        logic step;   // advance the burst counter on this edge
        logic wr;     // a lane write commits on this edge
        logic rd;     // output register loads on this edge
    } seq_ctl_t;

    // Low address bits of a burst: linear sum or interleaved XOR.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               linear
    );
        return linear ? base + cnt : base ^ cnt;
    endfunction

endpackage

// File: rtl/ssram_access_ctrl.sv
// Module ssram_access_ctrl
// Qualifies the two strobes against the chip selects. It decides on each edge
// whether a write commits, whether the output register loads and whether the
// burst counter steps, and it keeps the selected/deselected state.
// Assumes wr_req is the combinational "some lane requested" from the lane decode.
module ssram_access_ctrl
    import ssram_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_strobe_n,
    input  logic     ctl_strobe_n,
    input  logic     sel_main_n,
    input  logic     sel_hi,
    input  logic     sel_lo_n,
    input  logic     advance_n,
    input  logic     wr_req,
    output seq_ctl_t ctl,
    output logic     active_q
);

    logic cpu_acc;
    logic ctl_acc;
    logic strobe;
    logic selected;
    logic wr_last_q;

    // Strobe qualification: the processor strobe needs the primary select.
    always_comb begin
        cpu_acc  = ~cpu_strobe_n & ~sel_main_n;
        ctl_acc  = ~ctl_strobe_n & ~cpu_acc;
        strobe   = cpu_acc | ctl_acc;
        selected = ~sel_main_n & sel_hi & ~sel_lo_n;
    end

    // Edge decisions: same-edge controller write, continuation write, read load.
    always_comb begin
        ctl.load = strobe;
        ctl.step = ~strobe & active_q & ~advance_n;
        ctl.wr   = wr_req & ((ctl_acc & selected) | (~strobe & active_q));
        ctl.rd   = active_q & ~ctl.wr & ~wr_last_q;
    end

    // Selection state and write history for the turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            wr_last_q <= 1'b0;
        end else begin
            if (strobe) active_q <= selected;
            wr_last_q <= ctl.wr;
        end
    end

endmodule

// File: rtl/ssram_burst_addr.sv
// Module ssram_burst_addr
// Holds the captured base address and the burst counter. It gives the address
// in use now (read side) and the address after this edge (write side).
// Assumes DEPTH is a power of two and larger than one burst block.
module ssram_burst_addr
    import ssram_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          seq_linear,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] next_addr
);

    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;

    // Counter value that holds after this edge.
    always_comb begin
        if (load)      cnt_nx = '0;
        else if (step) cnt_nx = cnt_q + 1'b1;
        else           cnt_nx = cnt_q;
    end

    // Current and post-edge addresses in the selected burst order.
    always_comb begin
        cur_addr = {base_q[AW-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_q, seq_linear)};
        if (load) next_addr = addr_in;
        else      next_addr = {base_q[AW-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_nx, seq_linear)};
    end

    // Base capture on strobe edges and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) base_q <= addr_in;
            cnt_q <= cnt_nx;
        end
    end

endmodule

// File: rtl/ssram_lane_array.sv
// Module ssram_lane_array
// Decodes the global and per-lane write controls and holds the storage, one
// register array per byte lane. Reads are combinational from rd_addr.
// Assumes the storage contents are undefined until written (no reset).
module ssram_lane_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             wr_commit,
    input  logic [AW-1:0]    wr_addr,
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    rd_data,
    output logic             wr_any,
    output logic [LANES-1:0] lane_we
);

    logic [LANES-1:0] lane_req;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Lane request: global write, or per-lane enable with this lane selected.
        assign lane_req[i] = ~all_wr_n | (~lane_wr_en_n & ~lane_sel_n[i]);
        assign lane_we[i]  = lane_req[i] & wr_commit;

        // Lane storage write.
        always_ff @(posedge clk) begin
            if (lane_we[i]) cells[wr_addr] <= din[i*LANE_W +: LANE_W];
        end

        assign rd_data[i*LANE_W +: LANE_W] = cells[rd_addr];
    end

    assign wr_any = |lane_req;

endmodule

// File: rtl/ssram_out_stage.sv
// Module ssram_out_stage
// Output register plus the pipelined valid flag that holds the drive through
// the deselect edge. The enable is gated combinationally by the output-enable
// pin and by a pending write.
module ssram_out_stage #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_load,
    input  logic [DW-1:0] rd_data,
    input  logic          out_en_n,
    input  logic          wr_commit,
    output logic [DW-1:0] dout,
    output logic          dout_en
);

    logic valid_q;

    // Output register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            valid_q <= 1'b0;
        end else begin
            if (rd_load) dout <= rd_data;
            valid_q <= rd_load;
        end
    end

    // Drive enable: valid data, output enabled, no write pending.
    assign dout_en = valid_q & ~out_en_n & ~wr_commit;

endmodule

// File: rtl/burst_ssram.sv
// Module burst_ssram
// Top of the pipelined synchronous burst SRAM model. It joins the access
// controller, the burst address unit, the lane storage and the output stage.
// Assumes seq_linear is static while an access is active.
module burst_ssram
    import ssram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int DEPTH  = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             sel_main_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic [AW-1:0]    addr,
    input  logic             advance_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             seq_linear,
    input  logic             out_en_n,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);

    seq_ctl_t         seq;
    logic             active_q;
    logic             wr_any;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    rd_data;
    logic [LANES-1:0] lane_we;

    ssram_access_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .sel_main_n   (sel_main_n),
        .sel_hi       (sel_hi),
        .sel_lo_n     (sel_lo_n),
        .advance_n    (advance_n),
        .wr_req       (wr_any),
        .ctl          (seq),
        .active_q     (active_q)
    );

    ssram_burst_addr #(.DEPTH(DEPTH)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (seq.load),
        .step       (seq.step),
        .seq_linear (seq_linear),
        .addr_in    (addr),
        .cur_addr   (cur_addr),
        .next_addr  (wr_addr)
    );

    ssram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_mem (
        .clk          (clk),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .wr_commit    (seq.wr),
        .wr_addr      (wr_addr),
        .rd_addr      (cur_addr),
        .din          (din),
        .rd_data      (rd_data),
        .wr_any       (wr_any),
        .lane_we      (lane_we)
    );

    ssram_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_load   (seq.rd),
        .rd_data   (rd_data),
        .out_en_n  (out_en_n),
        .wr_commit (seq.wr),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: rtl/ssram_checker.sv
// Module ssram_checker
// Cycle-level properties of the burst SRAM, attached to burst_ssram by bind.
module ssram_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_strobe_n,
    input logic             ctl_strobe_n,
    input logic             sel_main_n,
    input logic             sel_hi,
    input logic             sel_lo_n,
    input logic             all_wr_n,
    input logic             out_en_n,
    input logic             dout_en,
    input logic             active_q,
    input logic             wr_commit,
    input logic [LANES-1:0] lane_we
);

    a_r2_cpu_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && sel_main_n && ctl_strobe_n && !active_q) |=> !active_q);

    a_r4_strobe_edge_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !sel_main_n) |-> (lane_we == '0));

    a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !all_wr_n) |-> (lane_we == '1));

    a_r7_reselect_float: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctl_strobe_n || !cpu_strobe_n) && !sel_main_n && sel_hi && !sel_lo_n && !active_q)
        |=> !dout_en);

    a_r8_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |=> !dout_en);

    a_r9_write_blank: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !dout_en);

    a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dout_en);

endmodule

bind burst_ssram ssram_checker #(.LANES(LANES)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .sel_main_n   (sel_main_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .all_wr_n     (all_wr_n),
    .out_en_n     (out_en_n),
    .dout_en      (dout_en),
    .active_q     (active_q),
    .wr_commit    (seq.wr),
    .lane_we      (lane_we)
);

// File: tb/test_burst_ssram.sv
// Scoreboard bench: the stimulus pushes expected driven words into a queue,
// and a monitor pops and compares them whenever dout_en is high.
module test_burst_ssram;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DEPTH  = 64;
    localparam int AW     = 6;
    localparam int DW     = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cpu_strobe_n, ctl_strobe_n, sel_main_n, sel_hi, sel_lo_n;
    logic [AW-1:0]    addr;
    logic             advance_n, all_wr_n, lane_wr_en_n, seq_linear, out_en_n;
    logic [LANES-1:0] lane_sel_n;
    logic [DW-1:0]    din, dout;
    logic             dout_en;

    typedef struct {
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] shadow [DEPTH];
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    always #10 clk = ~clk;

    burst_ssram i_burst_ssram (
        .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .sel_main_n(sel_main_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .addr(addr),
        .advance_n(advance_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_sel_n(lane_sel_n), .seq_linear(seq_linear), .out_en_n(out_en_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] word(input int a);
        return {4'hA, 8'(a), 8'(a) ^ 8'h5C, ~8'(a), 8'h3C ^ 8'(a)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input int a, input string tag);
        exp_t e;
        e.d   = shadow[a];
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Next cycle with every control idle and all selects active.
    task automatic nxt();
        @(negedge clk);
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1;
        sel_main_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
        advance_n = 1'b1; all_wr_n = 1'b1; lane_wr_en_n = 1'b1;
        lane_sel_n = '1; out_en_n = 1'b0; din = '0;
    endtask

    task automatic look_en(input logic exp, input string tag);
        #2;
        check(dout_en === exp, tag, {{(DW-1){1'b0}}, dout_en}, {{(DW-1){1'b0}}, exp});
    endtask

    task automatic desel();
        nxt(); ctl_strobe_n = 1'b0; sel_hi = 1'b0;
    endtask

    // Controller-strobe write; the shadow follows the lane rules of R6.
    task automatic wr_ctl(input int a, input logic [DW-1:0] d, input bit glob,
                          input bit lane_en, input logic [LANES-1:0] seln);
        nxt();
        ctl_strobe_n = 1'b0; addr = AW'(a); din = d;
        all_wr_n = ~glob; lane_wr_en_n = ~lane_en; lane_sel_n = seln;
        for (int i = 0; i < LANES; i++)
            if (glob || (lane_en && !seln[i]))
                shadow[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    endtask

    // Single read from the deselected state: two driven cycles (R1, R8).
    task automatic rd_single(input int a, input string tag);
        push(a, tag); push(a, tag);
        nxt(); ctl_strobe_n = 1'b0; addr = AW'(a);
        nxt();
        desel();
        nxt();
        nxt(); look_en(1'b0, tag);
    endtask

    // Four-beat burst read from the deselected state, then deselect.
    task automatic rd_burst(input int base, input int o0, input int o1, input int o2,
                            input int o3, input string tag);
        push(o0, tag); push(o1, tag); push(o2, tag); push(o3, tag); push(o0, tag);
        nxt(); ctl_strobe_n = 1'b0; addr = AW'(base);
        for (int k = 0; k < 4; k++) begin
            nxt(); advance_n = 1'b0;
        end
        desel();
        nxt();
        nxt(); look_en(1'b0, tag);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: every driven cycle must match the next expected word.
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (rst_n === 1'b1 && dout_en === 1'b1) begin
            if (sb.size() == 0) begin
                check(1'b0, "unexpected drive", dout, '0);
            end else begin
                e = sb.pop_front();
                check(dout === e.d, e.tag, dout, e.d);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; seq_linear = 1'b1; addr = '0;
        repeat (3) nxt();
        look_en(1'b0, "R12 drive after reset");
        check(dout === '0, "R12 output register cleared", dout, '0);
        nxt(); rst_n = 1'b1;

        // R5: controller-strobe writes, one edge each.
        wr_ctl(8, word(8), 1, 0, '1); look_en(1'b0, "R9 ctl write cycle");
        wr_ctl(9, word(9), 1, 0, '1);
        wr_ctl(10, word(10), 1, 0, '1);
        wr_ctl(12, word(12), 1, 0, '1);
        wr_ctl(20, word(20), 1, 0, '1);
        wr_ctl(22, word(22), 1, 0, '1);
        wr_ctl(23, word(23), 1, 0, '1);
        // R6: lanes 0 and 2 only; then global write overriding other inputs.
        wr_ctl(12, 36'h9_8765_4321, 0, 1, 4'b1010);
        wr_ctl(13, word(13), 1, 0, 4'b1111);
        desel(); nxt(); nxt(); look_en(1'b0, "R9 turnaround after write");

        // R1 / R3: back-to-back reads, second by processor strobe; R8 tail.
        push(8, "R1 R5 read 8"); push(9, "R3 read 9");
        push(10, "R3 read 10"); push(10, "R8 held drive");
        nxt(); ctl_strobe_n = 1'b0; addr = 6'd8;
        nxt(); ctl_strobe_n = 1'b0; addr = 6'd9;
        nxt(); cpu_strobe_n = 1'b0; addr = 6'd10;
        nxt();
        desel();
        nxt(); look_en(1'b1, "R8 driven one cycle after deselect");
        nxt(); look_en(1'b0, "R8 float after next edge");

        // R2: processor strobe without primary select leaves access at 9.
        repeat (4) push(9, "R2 ignored strobe");
        nxt(); ctl_strobe_n = 1'b0; addr = 6'd9;
        nxt(); look_en(1'b0, "R7 first cycle after reselect");
        nxt(); cpu_strobe_n = 1'b0; sel_main_n = 1'b1; addr = 6'd11;
        nxt();
        desel();
        nxt();
        nxt(); look_en(1'b0, "R8 float");

        // R10: output enable high blanks an otherwise driven cycle.
        push(8, "R10 read 8");
        nxt(); ctl_strobe_n = 1'b0; addr = 6'd8;
        nxt();
        desel(); out_en_n = 1'b1; look_en(1'b0, "R10 out_en_n high");
        nxt();
        nxt(); look_en(1'b0, "R10 tail");

        // R9: a continuation write blanks a valid read cycle.
        nxt(); ctl_strobe_n = 1'b0; addr = 6'd9;
        nxt();
        nxt(); all_wr_n = 1'b0; din = shadow[9]; look_en(1'b0, "R9 blank on write");
        desel();
        nxt();
        nxt(); look_en(1'b0, "R9 tail");

        // R4: processor-strobe write; strobe-edge data ignored, advance to 21.
        nxt(); cpu_strobe_n = 1'b0; addr = 6'd20; all_wr_n = 1'b0; din = ~word(20);
        nxt(); advance_n = 1'b0; all_wr_n = 1'b0; din = word(21);
        shadow[21] = word(21);
        look_en(1'b0, "R9 second-edge write");
        desel(); nxt(); nxt();

        // R11: linear then interleaved burst from base 21.
        rd_burst(21, 21, 22, 23, 20, "R11 linear R4");
        nxt(); seq_linear = 1'b0;
        rd_burst(21, 21, 20, 23, 22, "R11 interleaved");
        nxt(); seq_linear = 1'b1;

        // R6: lane merge and global override read back.
        rd_single(12, "R6 lane merge");
        rd_single(13, "R6 global override");

        nxt(); nxt();
        check(sb.size() == 0, "R1 all expected words driven", DW'(sb.size()), '0);
        done = 1'b1;
        report();
    end

endmodule